// File: doc/BRIEF.md
# Predicated Element Issue Sequencer

This block sits between instruction decode and the execution units. When decode presents a scalar instruction whose operand register is tagged as a vector, the sequencer takes it over. It holds the program counter and issues element operations one per cycle. The source and destination register numbers climb contiguously from the tagged base registers. The loop has two levels: an outer element index that runs up to the vector length (VL), and an inner sub-element index that runs up to the sub-vector length (SUBVL). The inner index moves fastest.

Each element group is gated by one bit of a predicate mask. The mask may come from the zero register and may be inverted. A clear bit either skips the group or issues zero-writes, depending on the zeroing mode. The element and sub-element offsets are architectural state, so a loop can start mid-way through. An exception on an element freezes the offsets so the loop resumes there after the trap. In fail-first mode, the loop instead stops at the first element that faults or yields a zero or false result. A stall input lets a downstream pipeline apply back-pressure.

Top module: `elem_issue_seq`

## Requirements
- R1: After a start is accepted, `pc_hold_o` is high from the next cycle until the loop ends. `done_o` is a one-cycle pulse, and `pc_hold_o` is already low in that cycle.
- R2: Operations come out element by element, with the sub-element index innermost. An operation for element e and sub-element s carries source register `src_base + (src_offs_start + e - dst_offs_start)*SUBVL + s` and destination register `dst_base + e*SUBVL + s`, both modulo 2^REG_W. `issue_elem_o` carries e and `issue_sub_o` carries s.
- R3: Bit e of the effective mask (bit 0 belongs to element 0) governs every sub-operation of element e.
- R4: The loop starts at the supplied destination and source offsets and the supplied sub-element offset, not at zero.
- R5: Without zeroing, an element whose effective bit is 0 issues nothing. It costs one cycle, and the offsets still advance past it.
- R6: With zeroing, an element whose effective bit is 0 issues all its sub-operations with `issue_zero_o` = 1.
- R7: Outside fail-first mode, `exc_i` raised with an issued operation produces a `trap_o` pulse in the next cycle, without `done_o`. The offsets remain at the faulting element and sub-element, and `pc_hold_o` drops.
- R8: When the final sub-operation of element VL-1 completes, all three offsets return to zero.
- R9: In fail-first mode, an issued operation with `exc_i` stops the loop, as does an active-bit operation with `res_zero_i` (a zero or false result, negative zero included). The next cycle then shows `ff_stop_o` and `done_o` together, `ff_len_o` equals that element's index, no trap is raised, and the offsets are zero.
- R10: When `mask_inv_i` is set, the mask is inverted before use. When `mask_x0_i` is set, the mask reads as all zeros, so with inversion every element is active.
- R11: A start with `mask_x0_i`, `mask_inv_i` and `zero_mode_i` all set is reserved. It gives an `illegal_o` pulse in the next cycle, issues nothing, and leaves `pc_hold_o` low.
- R12: With VL=1 and SUBVL=1, exactly one operation issues, and `done_o` arrives with `pc_hold_o` low in the cycle after it.
- R13: While `stall_i` is high, nothing issues and the indices hold. The sequence then continues with no element lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Decoded instruction uses a tagged register |
| vl_i | input | LW | Vector length, 1..MAXVL |
| subvl_i | input | SLW | Sub-vector length, 1..SUB_MAX |
| src_offs_i | input | OW | Stored source element offset to start from |
| dst_offs_i | input | OW | Stored destination element offset to start from |
| sub_offs_i | input | SW | Stored sub-element offset to start from |
| src_base_i | input | REG_W | Tagged source base register number |
| dst_base_i | input | REG_W | Tagged destination base register number |
| mask_i | input | MAXVL | Predicate mask register contents |
| mask_x0_i | input | 1 | Mask source is the zero register |
| mask_inv_i | input | 1 | Invert mask before use |
| zero_mode_i | input | 1 | Zeroing predication |
| ffirst_i | input | 1 | Fail-first mode |
| stall_i | input | 1 | Downstream back-pressure |
| exc_i | input | 1 | Issued operation raised an exception |
| res_zero_i | input | 1 | Issued operation gave a zero or false result |
| pc_hold_o | output | 1 | Program counter must not advance |
| issue_valid_o | output | 1 | Element operation issued this cycle |
| issue_zero_o | output | 1 | Operation is a zero-write of a masked-off element |
| issue_src_o | output | REG_W | Source register number |
| issue_dst_o | output | REG_W | Destination register number |
| issue_elem_o | output | OW | Destination element index |
| issue_sub_o | output | SW | Sub-element index |
| src_offs_o | output | OW | Architectural source offset |
| dst_offs_o | output | OW | Architectural destination offset |
| sub_offs_o | output | SW | Architectural sub-element offset |
| done_o | output | 1 | Loop finished (pulse) |
| trap_o | output | 1 | Loop stopped by an exception (pulse) |
| illegal_o | output | 1 | Reserved predicate encoding (pulse) |
| ff_stop_o | output | 1 | Fail-first stop (pulse) |
| ff_len_o | output | OW | Element index where fail-first stopped |

## Verification
The bench goes after the group boundaries. A sequencer that tested the predicate per sub-element, or that skipped one sub-op rather than a whole group, would give the wrong register numbers and cycle counts for SUBVL=3. Trap-then-resume is driven at a mid-group sub-element. A design that advanced past the faulting operation, or cleared the offsets, would lose that sub-op or replay earlier ones on resume. Fail-first is driven with both a zero result and a fault, to catch a design that traps instead of stopping, or that reports the wrong length. Stall, the reserved mask encoding and the single-element case each expose lost or duplicated issues, or a program counter released a cycle early or late.

// File: rtl/elemseq_pkg.sv
package elemseq_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  localparam int NUM_TRACKS = 2;   // index 0 = source, 1 = destination
  localparam int TRK_SRC = 0;
  localparam int TRK_DST = 1;

endpackage

// File: rtl/elemseq_pred.sv
module elemseq_pred #(
  parameter int MAXVL = 8,
  localparam int OW = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [MAXVL-1:0] mask_i,
  input  logic             from_x0_i,
  input  logic             inv_i,
  input  logic             zero_i,
  input  logic [OW-1:0]    idx_i,
  output logic             bit_o,
  output logic             zero_mode_o,
  output logic             reserved_o
);

  logic [MAXVL-1:0] eff_q;
  logic             zmode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_q   <= '0;
      zmode_q <= 1'b0;
    end else if (load_i) begin
      eff_q   <= (from_x0_i ? '0 : mask_i) ^ {MAXVL{inv_i}};
      zmode_q <= zero_i;
    end
  end

  assign bit_o       = eff_q[idx_i];
  assign zero_mode_o = zmode_q;
  assign reserved_o  = from_x0_i & inv_i & zero_i;

endmodule

// File: rtl/elemseq_track.sv
module elemseq_track #(
  parameter int MAXVL  = 8,
  parameter int REG_W  = 7,
  parameter int STEP_W = 3,
  localparam int OW = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [OW-1:0]     ld_offs_i,
  input  logic [REG_W-1:0]  ld_reg_i,
  input  logic              step_i,
  input  logic              elem_inc_i,
  input  logic [STEP_W-1:0] reg_inc_i,
  input  logic              clear_i,
  output logic [OW-1:0]     offs_o,
  output logic [REG_W-1:0]  reg_o
);

  logic [OW-1:0]    offs_q;
  logic [REG_W-1:0] reg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      offs_q <= '0;
      reg_q  <= '0;
    end else if (load_i) begin
      offs_q <= ld_offs_i;
      reg_q  <= ld_reg_i;
    end else if (clear_i) begin
      offs_q <= '0;
    end else if (step_i) begin
      if (elem_inc_i) offs_q <= offs_q + OW'(1);
      reg_q <= reg_q + REG_W'(reg_inc_i);
    end
  end

  assign offs_o = offs_q;
  assign reg_o  = reg_q;

endmodule

// File: rtl/elem_issue_seq.sv
module elem_issue_seq
  import elemseq_pkg::*;
#(
  parameter int MAXVL   = 8,
  parameter int REG_W   = 7,
  parameter int SUB_MAX = 4,
  localparam int OW  = (MAXVL > 1) ? $clog2(MAXVL) : 1,
  localparam int LW  = $clog2(MAXVL + 1),
  localparam int SW  = (SUB_MAX > 1) ? $clog2(SUB_MAX) : 1,
  localparam int SLW = $clog2(SUB_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [LW-1:0]    vl_i,
  input  logic [SLW-1:0]   subvl_i,
  input  logic [OW-1:0]    src_offs_i,
  input  logic [OW-1:0]    dst_offs_i,
  input  logic [SW-1:0]    sub_offs_i,
  input  logic [REG_W-1:0] src_base_i,
  input  logic [REG_W-1:0] dst_base_i,
  input  logic [MAXVL-1:0] mask_i,
  input  logic             mask_x0_i,
  input  logic             mask_inv_i,
  input  logic             zero_mode_i,
  input  logic             ffirst_i,
  input  logic             stall_i,
  input  logic             exc_i,
  input  logic             res_zero_i,
  output logic             pc_hold_o,
  output logic             issue_valid_o,
  output logic             issue_zero_o,
  output logic [REG_W-1:0] issue_src_o,
  output logic [REG_W-1:0] issue_dst_o,
  output logic [OW-1:0]    issue_elem_o,
  output logic [SW-1:0]    issue_sub_o,
  output logic [OW-1:0]    src_offs_o,
  output logic [OW-1:0]    dst_offs_o,
  output logic [SW-1:0]    sub_offs_o,
  output logic             done_o,
  output logic             trap_o,
  output logic             illegal_o,
  output logic             ff_stop_o,
  output logic [OW-1:0]    ff_len_o
);

  localparam int PW = OW + SLW;

  seq_state_e     state_q;
  logic [LW-1:0]  vl_q;
  logic [SLW-1:0] subvl_q;
  logic [SW-1:0]  sub_q;
  logic           ff_q;
  logic           done_q, trap_q, ill_q, ffs_q;
  logic [OW-1:0]  fflen_q;

  logic [OW-1:0]    offs   [NUM_TRACKS];
  logic [REG_W-1:0] regn   [NUM_TRACKS];
  logic [OW-1:0]    ld_offs[NUM_TRACKS];
  logic [REG_W-1:0] ld_reg [NUM_TRACKS];
  logic [REG_W-1:0] base   [NUM_TRACKS];

  logic run, idle, act, accept, reserved, pbit, zmode;
  logic do_issue, do_skip, fault, ff_hit, trap_hit, advance;
  logic last_sub, last_elem, elem_inc, finish, step, clear;
  logic [SLW-1:0] reg_step;

  elemseq_pred #(.MAXVL(MAXVL)) u_pred (
    .clk         (clk),
    .rst         (rst),
    .load_i      (accept),
    .mask_i      (mask_i),
    .from_x0_i   (mask_x0_i),
    .inv_i       (mask_inv_i),
    .zero_i      (zero_mode_i),
    .idx_i       (offs[TRK_DST]),
    .bit_o       (pbit),
    .zero_mode_o (zmode),
    .reserved_o  (reserved)
  );

  // Start values: base + offset*SUBVL + sub offset
  always_comb begin
    ld_offs[TRK_SRC] = src_offs_i;
    ld_offs[TRK_DST] = dst_offs_i;
    base[TRK_SRC]    = src_base_i;
    base[TRK_DST]    = dst_base_i;
    for (int g = 0; g < NUM_TRACKS; g++) begin
      ld_reg[g] = base[g] + REG_W'(PW'(ld_offs[g]) * PW'(subvl_i)) + REG_W'(sub_offs_i);
    end
  end

  for (genvar g = 0; g < NUM_TRACKS; g++) begin : g_track
    elemseq_track #(.MAXVL(MAXVL), .REG_W(REG_W), .STEP_W(SLW)) u_trk (
      .clk        (clk),
      .rst        (rst),
      .load_i     (accept),
      .ld_offs_i  (ld_offs[g]),
      .ld_reg_i   (ld_reg[g]),
      .step_i     (step),
      .elem_inc_i (elem_inc),
      .reg_inc_i  (reg_step),
      .clear_i    (clear),
      .offs_o     (offs[g]),
      .reg_o      (regn[g])
    );
  end

  always_comb begin
    run       = (state_q == SEQ_RUN);
    idle      = (state_q == SEQ_IDLE);
    accept    = idle & start_i & ~reserved;
    act       = run & ~stall_i;
    do_issue  = act & (pbit | zmode);
    do_skip   = act & ~pbit & ~zmode;
    fault     = do_issue & exc_i;
    ff_hit    = do_issue & ff_q & (exc_i | (pbit & res_zero_i));
    trap_hit  = fault & ~ff_q;
    advance   = (do_issue & ~trap_hit & ~ff_hit) | do_skip;
    last_sub  = (SLW'(sub_q) + SLW'(1)) == subvl_q;
    last_elem = (LW'(offs[TRK_DST]) + LW'(1)) == vl_q;
    elem_inc  = do_skip | last_sub;
    reg_step  = do_skip ? (subvl_q - SLW'(sub_q)) : SLW'(1);
    finish    = advance & elem_inc & last_elem;
    clear     = finish | ff_hit;
    step      = advance & ~finish;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      vl_q    <= LW'(1);
      subvl_q <= SLW'(1);
      ff_q    <= 1'b0;
      sub_q   <= '0;
      done_q  <= 1'b0;
      trap_q  <= 1'b0;
      ill_q   <= 1'b0;
      ffs_q   <= 1'b0;
      fflen_q <= '0;
    end else begin
      done_q <= clear;
      trap_q <= trap_hit;
      ill_q  <= idle & start_i & reserved;
      ffs_q  <= ff_hit;
      if (ff_hit) fflen_q <= offs[TRK_DST];

      if (accept) begin
        state_q <= SEQ_RUN;
        vl_q    <= vl_i;
        subvl_q <= subvl_i;
        ff_q    <= ffirst_i;
      end else if (clear | trap_hit) begin
        state_q <= SEQ_IDLE;
      end

      if (accept)       sub_q <= sub_offs_i;
      else if (clear)   sub_q <= '0;
      else if (advance) sub_q <= elem_inc ? '0 : sub_q + SW'(1);
    end
  end

  assign pc_hold_o     = run;
  assign issue_valid_o = do_issue;
  assign issue_zero_o  = ~pbit;
  assign issue_src_o   = regn[TRK_SRC];
  assign issue_dst_o   = regn[TRK_DST];
  assign issue_elem_o  = offs[TRK_DST];
  assign issue_sub_o   = sub_q;
  assign src_offs_o    = offs[TRK_SRC];
  assign dst_offs_o    = offs[TRK_DST];
  assign sub_offs_o    = sub_q;
  assign done_o        = done_q;
  assign trap_o        = trap_q;
  assign illegal_o     = ill_q;
  assign ff_stop_o     = ffs_q;
  assign ff_len_o      = fflen_q;

  // R1
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!pc_hold_o && $past(pc_hold_o)));

  // R8
  end_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !ff_stop_o) |-> (src_offs_o == '0 && dst_offs_o == '0 && sub_offs_o == '0));

  // R7
  trap_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> (dst_offs_o == $past(dst_offs_o) && sub_offs_o == $past(sub_offs_o)));

  // R13
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_hold_o && stall_i) |=> ($stable(dst_offs_o) && $stable(sub_offs_o)));

  // R11
  illegal_idle_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (!pc_hold_o && !done_o));

  // R2
  sub_range_chk: assert property (@(posedge clk) disable iff (rst)
    pc_hold_o |-> (SLW'(sub_q) < subvl_q));

endmodule

// File: tb/elem_issue_seq_bench.sv
module elem_issue_seq_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [3:0] vl_i = 4'd1;
  logic [2:0] subvl_i = 3'd1;
  logic [2:0] src_offs_i = '0, dst_offs_i = '0;
  logic [1:0] sub_offs_i = '0;
  logic [6:0] src_base_i = '0, dst_base_i = '0;
  logic [7:0] mask_i = '0;
  logic mask_x0_i = 0, mask_inv_i = 0, zero_mode_i = 0, ffirst_i = 0;
  logic stall_i = 0, exc_i = 0, res_zero_i = 0;

  logic       pc_hold_o, issue_valid_o, issue_zero_o;
  logic [6:0] issue_src_o, issue_dst_o;
  logic [2:0] issue_elem_o, src_offs_o, dst_offs_o, ff_len_o;
  logic [1:0] issue_sub_o, sub_offs_o;
  logic       done_o, trap_o, illegal_o, ff_stop_o;

  elem_issue_seq u_elem_issue_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .vl_i(vl_i), .subvl_i(subvl_i),
    .src_offs_i(src_offs_i), .dst_offs_i(dst_offs_i), .sub_offs_i(sub_offs_i),
    .src_base_i(src_base_i), .dst_base_i(dst_base_i), .mask_i(mask_i),
    .mask_x0_i(mask_x0_i), .mask_inv_i(mask_inv_i), .zero_mode_i(zero_mode_i),
    .ffirst_i(ffirst_i), .stall_i(stall_i), .exc_i(exc_i), .res_zero_i(res_zero_i),
    .pc_hold_o(pc_hold_o), .issue_valid_o(issue_valid_o), .issue_zero_o(issue_zero_o),
    .issue_src_o(issue_src_o), .issue_dst_o(issue_dst_o), .issue_elem_o(issue_elem_o),
    .issue_sub_o(issue_sub_o), .src_offs_o(src_offs_o), .dst_offs_o(dst_offs_o),
    .sub_offs_o(sub_offs_o), .done_o(done_o), .trap_o(trap_o), .illegal_o(illegal_o),
    .ff_stop_o(ff_stop_o), .ff_len_o(ff_len_o)
  );

  always #10 clk = ~clk;  // 50 MHz

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  logic [19:0] got [64];
  logic [19:0] exp_op [64];
  int n_got, n_exp;
  int f_elem, f_sub, z_elem, stall_at;
  int end_c, hold_cnt;
  bit saw_done, saw_trap, saw_ill, saw_ff, hold_end, st_valid, st_hold;
  int ff_len_seen;
  logic [4:0] st_key;

  task automatic chk_eq(string req, string what, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [19:0] pack(int s, int d, int z, int e, int sb);
    return {7'(s), 7'(d), 1'(z), 3'(e), 2'(sb)};
  endfunction

  task automatic build_exp(int vl, int svl, int so, int dof, int su, int sb, int db,
                           logic [7:0] m, bit x0, bit inv, bit z);
    n_exp = 0;
    for (int e = dof; e < vl; e++) begin
      bit eff;
      eff = x0 ? 1'b0 : m[e];
      if (inv) eff = ~eff;
      for (int s = (e == dof) ? su : 0; s < svl; s++) begin
        if (eff || z) begin
          exp_op[n_exp] = pack((sb + (so + e - dof) * svl + s) % 128,
                               (db + e * svl + s) % 128, eff ? 0 : 1, e, s);
          n_exp++;
        end
      end
    end
  endtask

  task automatic cmp_ops(string req);
    chk_eq(req, "op count", n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++)
      chk_eq(req, $sformatf("op %0d packed", i), int'(got[i]), int'(exp_op[i]));
  endtask

  task automatic launch(int vl, int svl, int so, int dof, int su, int sb, int db,
                        logic [7:0] m, bit x0, bit inv, bit z, bit ff);
    @(negedge clk);
    vl_i = 4'(vl); subvl_i = 3'(svl);
    src_offs_i = 3'(so); dst_offs_i = 3'(dof); sub_offs_i = 2'(su);
    src_base_i = 7'(sb); dst_base_i = 7'(db); mask_i = m;
    mask_x0_i = x0; mask_inv_i = inv; zero_mode_i = z; ffirst_i = ff;
    start_i = 1'b1;
  endtask

  task automatic collect();
    n_got = 0; end_c = -1; hold_cnt = 0;
    saw_done = 0; saw_trap = 0; saw_ill = 0; saw_ff = 0; hold_end = 0;
    st_valid = 0; st_hold = 0; ff_len_seen = -1;
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      start_i = 1'b0;
      stall_i = (c == stall_at);
      #1;
      exc_i = issue_valid_o && int'(issue_elem_o) == f_elem && int'(issue_sub_o) == f_sub;
      res_zero_i = issue_valid_o && int'(issue_elem_o) == z_elem;
      #1;
      if (done_o || trap_o || illegal_o) begin
        end_c = c; saw_done = done_o; saw_trap = trap_o; saw_ill = illegal_o;
        saw_ff = ff_stop_o; ff_len_seen = int'(ff_len_o); hold_end = pc_hold_o;
        break;
      end
      if (pc_hold_o) hold_cnt++;
      if (c == stall_at) begin
        st_valid = issue_valid_o; st_key = {dst_offs_o, sub_offs_o};
      end
      if (c == stall_at + 1) st_hold = ({dst_offs_o, sub_offs_o} == st_key);
      if (issue_valid_o) begin
        got[n_got] = {issue_src_o, issue_dst_o, issue_zero_o, issue_elem_o, issue_sub_o};
        n_got++;
      end
    end
    stall_i = 0; exc_i = 0; res_zero_i = 0;
    f_elem = -1; f_sub = -1; z_elem = -1; stall_at = -1;
  endtask

  task automatic t_reset();
    chk_eq("R1", "pc_hold after reset", int'(pc_hold_o), 0);
    chk_eq("R8", "offsets after reset", int'({src_offs_o, dst_offs_o, sub_offs_o}), 0);
    chk_eq("R2", "issue_valid after reset", int'(issue_valid_o), 0);
  endtask

  task automatic t_basic();
    launch(4, 1, 0, 0, 0, 10, 20, 8'hFF, 0, 0, 0, 0);
    collect();
    build_exp(4, 1, 0, 0, 0, 10, 20, 8'hFF, 0, 0, 0);
    cmp_ops("R2");
    chk_eq("R1", "done cycle", end_c, 4);
    chk_eq("R1", "hold cycles", hold_cnt, 4);
    chk_eq("R1", "pc_hold at done", int'(hold_end), 0);
    chk_eq("R8", "offsets at done", int'({src_offs_o, dst_offs_o, sub_offs_o}), 0);
  endtask

  task automatic t_group();
    launch(3, 3, 0, 0, 0, 5, 40, 8'b101, 0, 0, 0, 0);
    collect();
    build_exp(3, 3, 0, 0, 0, 5, 40, 8'b101, 0, 0, 0);
    cmp_ops("R3");
    chk_eq("R5", "done cycle with one skipped group", end_c, 7);
  endtask

  task automatic t_zero();
    launch(3, 3, 0, 0, 0, 5, 40, 8'b101, 0, 0, 1, 0);
    collect();
    build_exp(3, 3, 0, 0, 0, 5, 40, 8'b101, 0, 0, 1);
    cmp_ops("R6");
    chk_eq("R6", "done cycle zeroing", end_c, 9);
  endtask

  task automatic t_inv();
    launch(4, 1, 0, 0, 0, 1, 2, 8'b0011, 0, 1, 0, 0);
    collect();
    build_exp(4, 1, 0, 0, 0, 1, 2, 8'b0011, 0, 1, 0);
    cmp_ops("R10");
    launch(4, 1, 0, 0, 0, 1, 2, 8'h00, 1, 1, 0, 0);
    collect();
    chk_eq("R10", "x0 inverted op count", n_got, 4);
    launch(4, 1, 0, 0, 0, 1, 2, 8'hFF, 1, 0, 0, 0);
    collect();
    chk_eq("R10", "x0 plain op count", n_got, 0);
    chk_eq("R5", "x0 plain done cycle", end_c, 4);
  endtask

  task automatic t_reserved();
    launch(4, 1, 0, 0, 0, 1, 2, 8'hFF, 1, 1, 1, 0);
    collect();
    chk_eq("R11", "illegal pulse", int'(saw_ill), 1);
    chk_eq("R11", "illegal cycle", end_c, 0);
    chk_eq("R11", "no done", int'(saw_done), 0);
    chk_eq("R11", "pc_hold", int'(hold_end), 0);
    repeat (3) @(negedge clk);
    chk_eq("R11", "still idle", int'(pc_hold_o), 0);
  endtask

  task automatic t_single();
    launch(1, 1, 0, 0, 0, 9, 17, 8'h01, 0, 0, 0, 0);
    collect();
    chk_eq("R12", "op count", n_got, 1);
    chk_eq("R12", "done cycle", end_c, 1);
    chk_eq("R12", "pc_hold at done", int'(hold_end), 0);
  endtask

  task automatic t_resume();
    launch(5, 2, 2, 2, 1, 30, 60, 8'hFF, 0, 0, 0, 0);
    collect();
    build_exp(5, 2, 2, 2, 1, 30, 60, 8'hFF, 0, 0, 0);
    cmp_ops("R4");
    chk_eq("R4", "done cycle", end_c, 5);
  endtask

  task automatic t_trap();
    int so, dof, su;
    f_elem = 2; f_sub = 1;
    launch(4, 2, 0, 0, 0, 3, 50, 8'hFF, 0, 0, 0, 0);
    collect();
    build_exp(4, 2, 0, 0, 0, 3, 50, 8'hFF, 0, 0, 0);
    n_exp = 6;
    cmp_ops("R7");
    chk_eq("R7", "trap pulse", int'(saw_trap), 1);
    chk_eq("R7", "no done", int'(saw_done), 0);
    chk_eq("R7", "trap cycle", end_c, 6);
    chk_eq("R7", "pc_hold after trap", int'(hold_end), 0);
    chk_eq("R7", "dst offs frozen", int'(dst_offs_o), 2);
    chk_eq("R7", "src offs frozen", int'(src_offs_o), 2);
    chk_eq("R7", "sub offs frozen", int'(sub_offs_o), 1);
    so = int'(src_offs_o); dof = int'(dst_offs_o); su = int'(sub_offs_o);
    launch(4, 2, so, dof, su, 3, 50, 8'hFF, 0, 0, 0, 0);
    collect();
    build_exp(4, 2, so, dof, su, 3, 50, 8'hFF, 0, 0, 0);
    cmp_ops("R4");
    chk_eq("R8", "offsets after resumed loop", int'({src_offs_o, dst_offs_o, sub_offs_o}), 0);
  endtask

  task automatic t_ffirst();
    z_elem = 3;
    launch(6, 1, 0, 0, 0, 0, 8, 8'hFF, 0, 0, 0, 1);
    collect();
    build_exp(6, 1, 0, 0, 0, 0, 8, 8'hFF, 0, 0, 0);
    n_exp = 4;
    cmp_ops("R9");
    chk_eq("R9", "ff stop pulse", int'(saw_ff), 1);
    chk_eq("R9", "ff length", ff_len_seen, 3);
    chk_eq("R9", "done with stop", int'(saw_done), 1);
    chk_eq("R9", "offsets cleared", int'({src_offs_o, dst_offs_o, sub_offs_o}), 0);
    f_elem = 1; f_sub = 0;
    launch(6, 1, 0, 0, 0, 0, 8, 8'hFF, 0, 0, 0, 1);
    collect();
    chk_eq("R9", "fault op count", n_got, 2);
    chk_eq("R9", "fault ff length", ff_len_seen, 1);
    chk_eq("R9", "fault gives no trap", int'(saw_trap), 0);
  endtask

  task automatic t_stall();
    stall_at = 2;
    launch(3, 2, 0, 0, 0, 12, 70, 8'hFF, 0, 0, 0, 0);
    collect();
    build_exp(3, 2, 0, 0, 0, 12, 70, 8'hFF, 0, 0, 0);
    cmp_ops("R13");
    chk_eq("R13", "no issue while stalled", int'(st_valid), 0);
    chk_eq("R13", "indices held", int'(st_hold), 1);
    chk_eq("R13", "done cycle", end_c, 7);
  endtask

  initial begin
    f_elem = -1; f_sub = -1; z_elem = -1; stall_at = -1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_group();
    t_zero();
    t_inv();
    t_reserved();
    t_single();
    t_resume();
    t_trap();
    t_ffirst();
    t_stall();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule